// File: doc/BRIEF.md
# 8b/10b Symbol Decoder with Big-Endian Word Packing

This block takes framed 10-bit line symbols, one per clock when a strobe says so. It turns each symbol back into its 8-bit byte and raises a flag when the symbol is a control character. It keeps the running disparity of the line and marks every symbol that is not a legal code word, or that breaks the disparity rules, as a code error.

Legal data bytes are then packed into 32-bit words. The first byte of a word lands in the top byte lane. A start-of-transmission control character (K.28.1, byte value 0x3C) returns the packer to the top lane, so word boundaries line up again at the start of every transmission. Recovery of the serial stream and framing into symbols are handled upstream.

Top module: `tdc_sym_decoder`

## Requirements
- R1: Symbol bit 0 holds line bit a, and bits 1 to 9 hold b, c, d, e, i, f, g, h, j in that order. Byte bit 0 is A and bit 7 is H, so the decoded byte of D.x.y is {y[2:0], x[4:0]}. The decoding follows the standard 5b/6b and 3b/4b code tables.
- R2: `ctrl_o` is high with a legal K.28.y symbol or a legal K.23.7, K.27.7, K.29.7 or K.30.7 symbol. `byte_o` then carries that character's x/y value. `ctrl_o` is never high together with `code_err_o`.
- R3: Running disparity is negative after reset. The 6-bit and the 4-bit sub-blocks each move it: two more ones than zeros make it positive, two more zeros than ones make it negative, and a balanced sub-block leaves it unchanged.
- R4: `code_err_o` is high for a symbol in any of these cases: a sub-block is not in the code tables; a +2 sub-block arrives while the disparity is positive; a -2 sub-block arrives while the disparity is negative; 111000 or 1100 arrives while the disparity is positive; 000111 or 0011 arrives while the disparity is negative. These sub-blocks are written in line order, a first.
- R5: A symbol presented while `sym_valid_i` is low is ignored. It gives no output strobe, no error, and no change to the running disparity.
- R6: `byte_valid_o`, `byte_o`, `ctrl_o` and `code_err_o` reflect an accepted symbol one clock after it is taken. `byte_valid_o` is high for exactly that one clock.
- R7: Data bytes (no control flag, no error) fill a word in order bits 31:24, 23:16, 15:8, 7:0.
- R8: `word_valid_o` pulses for one clock, with the completed word on `word_o`. This happens one clock after the fourth data byte of a word appears on the byte outputs.
- R9: A K.28.1 character resets the byte lane, so the next data byte goes to bits 31:24. Other control characters and errored symbols are not packed and do not move the lane.
- R10: Synchronous active-high reset clears all outputs and the byte lane, and sets the disparity to negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_i | input | 10 | Line symbol, bit 0 = a ... bit 9 = j |
| sym_valid_i | input | 1 | Symbol strobe |
| byte_o | output | 8 | Decoded byte, bit 0 = A |
| byte_valid_o | output | 1 | One-clock strobe for a decoded symbol |
| ctrl_o | output | 1 | Symbol was a control character |
| code_err_o | output | 1 | Symbol was illegal or broke disparity |
| word_o | output | 32 | Assembled word, first byte in bits 31:24 |
| word_valid_o | output | 1 | One-clock strobe for a finished word |

## Verification
The assertions watch relations that must hold on every cycle. Running disparity stays frozen while no symbol is strobed. A control flag never appears together with an error. Every output strobe traces back to an input strobe one clock earlier. A word strobe lasts one clock and follows a data byte. A start character always empties the lane. Only the bench scenarios can show that actual code words decode to the right byte values. They also show the disparity carried across a long symbol sequence, bytes landing in big-endian order, realignment after a start character, and errored or other control symbols being left out of the word.

// File: rtl/tdc_sym_pkg.sv
package tdc_sym_pkg;

    localparam int SYM_W  = 10;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] START_BYTE = 8'h3C;  // K.28.1

    typedef enum logic [1:0] {
        DSP_NEG2,
        DSP_ZERO,
        DSP_POS2,
        DSP_BAD
    } dsp_e;

    typedef struct packed {
        logic       ok;
        logic       k28;
        logic [4:0] x;
    } six_t;

    typedef struct packed {
        logic       ok;
        logic [2:0] y;
    } four_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              ctrl;
        logic              err;
    } dec_t;

    // 6-bit sub-block written a,b,c,d,e,i with a as MSB
    function automatic six_t lookup6(input logic [5:0] c);
        six_t r;
        r = '{ok: 1'b1, k28: 1'b0, x: 5'd0};
        case (c)
            6'b100111, 6'b011000: r.x = 5'd0;
            6'b011101, 6'b100010: r.x = 5'd1;
            6'b101101, 6'b010010: r.x = 5'd2;
            6'b110001:            r.x = 5'd3;
            6'b110101, 6'b001010: r.x = 5'd4;
            6'b101001:            r.x = 5'd5;
            6'b011001:            r.x = 5'd6;
            6'b111000, 6'b000111: r.x = 5'd7;
            6'b111001, 6'b000110: r.x = 5'd8;
            6'b100101:            r.x = 5'd9;
            6'b010101:            r.x = 5'd10;
            6'b110100:            r.x = 5'd11;
            6'b001101:            r.x = 5'd12;
            6'b101100:            r.x = 5'd13;
            6'b011100:            r.x = 5'd14;
            6'b010111, 6'b101000: r.x = 5'd15;
            6'b011011, 6'b100100: r.x = 5'd16;
            6'b100011:            r.x = 5'd17;
            6'b010011:            r.x = 5'd18;
            6'b110010:            r.x = 5'd19;
            6'b001011:            r.x = 5'd20;
            6'b101010:            r.x = 5'd21;
            6'b011010:            r.x = 5'd22;
            6'b111010, 6'b000101: r.x = 5'd23;
            6'b110011, 6'b001100: r.x = 5'd24;
            6'b100110:            r.x = 5'd25;
            6'b010110:            r.x = 5'd26;
            6'b110110, 6'b001001: r.x = 5'd27;
            6'b001110:            r.x = 5'd28;
            6'b101110, 6'b010001: r.x = 5'd29;
            6'b011110, 6'b100001: r.x = 5'd30;
            6'b101011, 6'b010100: r.x = 5'd31;
            6'b001111, 6'b110000: begin r.x = 5'd28; r.k28 = 1'b1; end
            default:              r.ok = 1'b0;
        endcase
        return r;
    endfunction

    // 4-bit sub-block written f,g,h,j with f as MSB
    function automatic four_t lookup4(input logic [3:0] c);
        four_t r;
        r = '{ok: 1'b1, y: 3'd0};
        case (c)
            4'b1011, 4'b0100:                   r.y = 3'd0;
            4'b1001:                            r.y = 3'd1;
            4'b0101:                            r.y = 3'd2;
            4'b1100, 4'b0011:                   r.y = 3'd3;
            4'b1101, 4'b0010:                   r.y = 3'd4;
            4'b1010:                            r.y = 3'd5;
            4'b0110:                            r.y = 3'd6;
            4'b1110, 4'b0001, 4'b0111, 4'b1000: r.y = 3'd7;
            default:                            r.ok = 1'b0;
        endcase
        return r;
    endfunction

    function automatic dsp_e disp6(input logic [5:0] c);
        case ($countones(c))
            2:       return DSP_NEG2;
            3:       return DSP_ZERO;
            4:       return DSP_POS2;
            default: return DSP_BAD;
        endcase
    endfunction

    function automatic dsp_e disp4(input logic [3:0] c);
        case ($countones(c))
            1:       return DSP_NEG2;
            2:       return DSP_ZERO;
            3:       return DSP_POS2;
            default: return DSP_BAD;
        endcase
    endfunction

    // disparity violation of one sub-block given the entering disparity (1 = positive)
    function automatic logic dsp_violation(input dsp_e d, input logic rd_pos);
        return (d == DSP_BAD) || (d == DSP_POS2 && rd_pos) || (d == DSP_NEG2 && !rd_pos);
    endfunction

    function automatic logic dsp_after(input dsp_e d, input logic rd_pos);
        return (d == DSP_POS2) ? 1'b1 : (d == DSP_NEG2) ? 1'b0 : rd_pos;
    endfunction

endpackage

// File: rtl/tdc_sym_decode.sv
module tdc_sym_decode
    import tdc_sym_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SYM_W-1:0]  sym_i,
    input  logic              valid_i,
    output dec_t              dec_o,
    output logic              valid_o
);

    logic [5:0] c6;
    logic [3:0] c4;
    logic [3:0] c4_eff;
    six_t       s6;
    four_t      s4;
    dsp_e       d6;
    dsp_e       d4;
    logic       rd_q;
    logic       rd_mid;
    logic       rd_end;
    logic       bad6;
    logic       bad4;
    logic       is_k7;
    dec_t       dec_d;
    dec_t       dec_q;
    logic       valid_q;

    always_comb begin
        c6     = {sym_i[0], sym_i[1], sym_i[2], sym_i[3], sym_i[4], sym_i[5]};
        c4     = {sym_i[6], sym_i[7], sym_i[8], sym_i[9]};
        // a K.28 sent at positive disparity is the bitwise complement of its negative form
        c4_eff = (c6 == 6'b110000) ? ~c4 : c4;
        s6     = lookup6(c6);
        s4     = lookup4(c4_eff);
        d6     = disp6(c6);
        d4     = disp4(c4);

        bad6   = !s6.ok || dsp_violation(d6, rd_q)
               || (c6 == 6'b111000 && rd_q) || (c6 == 6'b000111 && !rd_q);
        rd_mid = dsp_after(d6, rd_q);
        bad4   = !s4.ok || dsp_violation(d4, rd_mid)
               || (c4 == 4'b1100 && rd_mid) || (c4 == 4'b0011 && !rd_mid);
        rd_end = dsp_after(d4, rd_mid);

        is_k7  = (s6.x == 5'd23 || s6.x == 5'd27 || s6.x == 5'd29 || s6.x == 5'd30)
               && (c4 == 4'b0111 || c4 == 4'b1000);

        dec_d.data = {s4.y, s6.x};
        dec_d.err  = bad6 || bad4;
        dec_d.ctrl = (s6.k28 || is_k7) && !(bad6 || bad4);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q    <= 1'b0;
            dec_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= valid_i;
            if (valid_i) begin
                rd_q  <= rd_end;
                dec_q <= dec_d;
            end else begin
                dec_q.ctrl <= 1'b0;
                dec_q.err  <= 1'b0;
            end
        end
    end

    assign dec_o   = dec_q;
    assign valid_o = valid_q;

    // R5: disparity is untouched while no symbol is strobed
    p_rd_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(rd_q));

    // R6: every output strobe comes from an input strobe one clock earlier
    p_out_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(valid_i));

    // R2: a control flag never travels with an error
    p_ctrl_clean_r2: assert property (@(posedge clk) disable iff (rst)
        dec_o.ctrl |-> !dec_o.err);

endmodule

// File: rtl/tdc_word_pack.sv
module tdc_word_pack
    import tdc_sym_pkg::*;
#(
    parameter int WORD_BYTES = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  dec_t                         dec_i,
    input  logic                         valid_i,
    output logic [WORD_BYTES*BYTE_W-1:0] word_o,
    output logic                         word_valid_o
);

    localparam int WORD_W = WORD_BYTES * BYTE_W;
    localparam int POS_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_BYTES - 1);

    logic [POS_W-1:0]  pos_q;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] word_q;
    logic              wv_q;
    logic              take;
    logic              start;
    logic [WORD_W-1:0] acc_next;

    assign take     = valid_i && !dec_i.ctrl && !dec_i.err;
    assign start    = valid_i && dec_i.ctrl && (dec_i.data == START_BYTE);
    assign acc_next = {acc_q[WORD_W-BYTE_W-1:0], dec_i.data};

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            acc_q  <= '0;
            word_q <= '0;
            wv_q   <= 1'b0;
        end else begin
            wv_q <= 1'b0;
            if (start) begin
                pos_q <= '0;
            end else if (take) begin
                acc_q <= acc_next;
                if (pos_q == LAST_POS) begin
                    pos_q  <= '0;
                    word_q <= acc_next;
                    wv_q   <= 1'b1;
                end else begin
                    pos_q <= pos_q + 1'b1;
                end
            end
        end
    end

    assign word_o       = word_q;
    assign word_valid_o = wv_q;

    // R8: a word strobe is caused by a data byte one clock earlier
    p_word_src_r8: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |-> $past(take));

    // R8: a word strobe lasts exactly one clock
    p_word_single_r8: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |=> !word_valid_o);

    // R9: a start character returns the packer to the top lane
    p_start_clear_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> (pos_q == '0));

endmodule

// File: rtl/tdc_sym_decoder.sv
module tdc_sym_decoder
    import tdc_sym_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [9:0]  sym_i,
    input  logic        sym_valid_i,
    output logic [7:0]  byte_o,
    output logic        byte_valid_o,
    output logic        ctrl_o,
    output logic        code_err_o,
    output logic [31:0] word_o,
    output logic        word_valid_o
);

    dec_t dec;
    logic dec_valid;

    tdc_sym_decode u_decode (
        .clk     (clk),
        .rst     (rst),
        .sym_i   (sym_i),
        .valid_i (sym_valid_i),
        .dec_o   (dec),
        .valid_o (dec_valid)
    );

    tdc_word_pack #(.WORD_BYTES(4)) u_pack (
        .clk          (clk),
        .rst          (rst),
        .dec_i        (dec),
        .valid_i      (dec_valid),
        .word_o       (word_o),
        .word_valid_o (word_valid_o)
    );

    assign byte_o       = dec.data;
    assign byte_valid_o = dec_valid;
    assign ctrl_o       = dec.ctrl;
    assign code_err_o   = dec.err;

endmodule

// File: tb/tdc_sym_decoder_bench.sv
`timescale 1ns/1ps
module tdc_sym_decoder_bench;

    typedef struct packed {
        logic [9:0]  code;   // written a..j, a as MSB
        logic [7:0]  b;
        logic        k;
        logic        e;
        logic        wv;
        logic [31:0] w;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{10'b0011111001, 8'h3C, 1'b1, 1'b0, 1'b0, 32'h0},         // K.28.1 rd-
        '{10'b0110001011, 8'h00, 1'b0, 1'b0, 1'b0, 32'h0},         // D.0.0 rd+
        '{10'b1100010011, 8'h63, 1'b0, 1'b0, 1'b0, 32'h0},         // D.3.3 rd+
        '{10'b1010101010, 8'hB5, 1'b0, 1'b0, 1'b0, 32'h0},         // D.21.5
        '{10'b0001110001, 8'hE7, 1'b0, 1'b0, 1'b1, 32'h0063B5E7},  // D.7.7 rd+
        '{10'b1010110100, 8'h1F, 1'b0, 1'b0, 1'b0, 32'h0},         // D.31.0 rd-
        '{10'b0101110010, 8'h8F, 1'b0, 1'b0, 1'b0, 32'h0},         // D.15.4 rd-
        '{10'b0011111010, 8'hBC, 1'b1, 1'b0, 1'b0, 32'h0},         // K.28.5 rd-, not packed
        '{10'b0101010101, 8'h4A, 1'b0, 1'b0, 1'b0, 32'h0},         // D.10.2
        '{10'b0011000110, 8'hD8, 1'b0, 1'b0, 1'b1, 32'h1F8F4AD8},  // D.24.6 rd+
        '{10'b0111010100, 8'h01, 1'b0, 1'b0, 1'b0, 32'h0},         // D.1.0 rd-
        '{10'b0011111001, 8'h3C, 1'b1, 1'b0, 1'b0, 32'h0},         // K.28.1 realigns
        '{10'b1010010110, 8'hC5, 1'b0, 1'b0, 1'b0, 32'h0},         // D.5.6
        '{10'b1000111001, 8'h31, 1'b0, 1'b0, 1'b0, 32'h0},         // D.17.1
        '{10'b1001011010, 8'hA9, 1'b0, 1'b0, 1'b0, 32'h0},         // D.9.5
        '{10'b0001011110, 8'hF7, 1'b0, 1'b0, 1'b1, 32'hC531A9F7},  // D.23.7 rd+
        '{10'b1100000110, 8'h3C, 1'b1, 1'b0, 1'b0, 32'h0},         // K.28.1 rd+
        '{10'b0110001011, 8'h00, 1'b0, 1'b1, 1'b0, 32'h0},         // -2 block at rd-
        '{10'b0000001111, 8'h00, 1'b0, 1'b1, 1'b0, 32'h0},         // not a code word
        '{10'b0110001011, 8'h00, 1'b0, 1'b0, 1'b0, 32'h0},         // D.0.0 rd+
        '{10'b1100010011, 8'h63, 1'b0, 1'b0, 1'b0, 32'h0},         // D.3.3 rd+
        '{10'b1010101010, 8'hB5, 1'b0, 1'b0, 1'b0, 32'h0},         // D.21.5
        '{10'b0001110001, 8'hE7, 1'b0, 1'b0, 1'b1, 32'h0063B5E7}   // D.7.7 rd+
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  sym = '0;
    logic        vld = 1'b0;
    logic [7:0]  byte_o;
    logic        byte_valid_o;
    logic        ctrl_o;
    logic        code_err_o;
    logic [31:0] word_o;
    logic        word_valid_o;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    tdc_sym_decoder u_tdc_sym_decoder (
        .clk          (clk),
        .rst          (rst),
        .sym_i        (sym),
        .sym_valid_i  (vld),
        .byte_o       (byte_o),
        .byte_valid_o (byte_valid_o),
        .ctrl_o       (ctrl_o),
        .code_err_o   (code_err_o),
        .word_o       (word_o),
        .word_valid_o (word_valid_o)
    );

    function automatic logic [9:0] line(input logic [9:0] c);
        logic [9:0] r;
        for (int i = 0; i < 10; i++) r[i] = c[9-i];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one symbol, then one idle clock; checks byte outputs and the word strobe
    task automatic run_vec(input vec_t v);
        @(negedge clk);
        sym = line(v.code);
        vld = 1'b1;
        @(posedge clk); #1;
        chk("R6 byte_valid", {31'd0, byte_valid_o}, 32'd1);
        chk("R4 code_err", {31'd0, code_err_o}, {31'd0, v.e});
        if (!v.e) begin
            chk("R1 byte", {24'd0, byte_o}, {24'd0, v.b});
            chk("R2 ctrl", {31'd0, ctrl_o}, {31'd0, v.k});
        end
        @(negedge clk);
        vld = 1'b0;
        @(posedge clk); #1;
        chk("R6 strobe one clock", {31'd0, byte_valid_o}, 32'd0);
        chk("R8 word_valid", {31'd0, word_valid_o}, {31'd0, v.wv});
        if (v.wv) chk("R7 word order", word_o, v.w);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk("R10 byte_valid", {31'd0, byte_valid_o}, 32'd0);
        chk("R10 word_valid", {31'd0, word_valid_o}, 32'd0);
        chk("R10 word", word_o, 32'd0);
        chk("R10 byte", {24'd0, byte_o}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // table walk: R1 R2 R3 R4 R7 R8 R9
        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R5: illegal symbol without strobe is ignored; disparity stays negative
        @(negedge clk);
        sym = line(10'b0000001111);
        vld = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            chk("R5 no strobe", {31'd0, byte_valid_o}, 32'd0);
            chk("R5 no error", {31'd0, code_err_o}, 32'd0);
        end
        run_vec('{10'b0111010100, 8'h01, 1'b0, 1'b0, 1'b0, 32'h0});  // D.1.0 rd- legal only if R5 held

        // R9 + R8: back-to-back strobes, K.28.1 then four neutral data symbols
        @(negedge clk); sym = line(10'b0011111001); vld = 1'b1;
        @(negedge clk); sym = line(10'b1010101010);
        @(negedge clk); sym = line(10'b1010101010);
        @(negedge clk); sym = line(10'b0101010101);
        @(negedge clk); sym = line(10'b1001011010);
        @(negedge clk); vld = 1'b0;
        @(posedge clk); #1;
        chk("R8 word_valid back-to-back", {31'd0, word_valid_o}, 32'd1);
        chk("R9 realigned word", word_o, 32'hB5B54AA9);
        @(posedge clk); #1;
        chk("R8 word_valid drops", {31'd0, word_valid_o}, 32'd0);

        // R10: reset mid-word clears lane and disparity
        run_vec('{10'b1010101010, 8'hB5, 1'b0, 1'b0, 1'b0, 32'h0});
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        run_vec('{10'b1001110100, 8'h00, 1'b0, 1'b0, 1'b0, 32'h0});  // D.0.0 rd- (R3 after reset)
        run_vec('{10'b1010101010, 8'hB5, 1'b0, 1'b0, 1'b0, 32'h0});
        run_vec('{10'b1010101010, 8'hB5, 1'b0, 1'b0, 1'b0, 32'h0});
        run_vec('{10'b1010101010, 8'hB5, 1'b0, 1'b0, 1'b1, 32'h00B5B5B5});

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule